// File: doc/BRIEF.md
# ADC Sample Output Formatter

This block sits between a 14-bit converter core and the chip's digital output pins. Once per sample period it takes one converter sample and its out-of-range flag. It can swap the sample for a generated test pattern, and it can recode the result from offset binary to two's complement. The finished word is held for one full sample period and driven out in one of two output standards.

In the single-rate standard the whole word appears on a 14-bit parallel bus. In the double-rate standard the word is folded onto seven lanes. Each lane carries one bit during the first half of the sample period and another bit during the second half, so the lanes change on both edges of the sample clock. Two lane orderings are available: pairs of neighbouring bits, or low half then high half.

A data-valid clock goes out alongside the data. Its edge can be delayed in eighths of a sample period, and it can be inverted. The block runs from a single phase clock at eight times the sample rate. An internal tick counter, cleared by reset, marks the sample period, the lane halves and the data-valid edges. All configuration inputs are static fields written by the register block.

Top module: `adc_out_formatter`

## Requirements
- R1: The sample present on the tick-7 edge of a period (tick counter 7 → 0) is captured. That word, and its flag, is shown on the outputs for all eight ticks of the next period.
- R2: With `cfgDdr`=0, `parOut` carries the captured word and `laneOut` is all zeros.
- R3: With `cfgDdr`=1 and `cfgByteOrder`=0, lane i carries word bit 2i during ticks 0–3 and word bit 2i+1 during ticks 4–7. In this mode `parOut` is all zeros.
- R4: With `cfgDdr`=1 and `cfgByteOrder`=1, lane i carries word bit i during ticks 0–3 and word bit 7+i during ticks 4–7.
- R5: `cfgFormat`=01 gives two's complement, formed by inverting bit 13. Codes 00, 10 and 11 pass the offset-binary code through unchanged.
- R6: `cfgPattern` selects the word source: 000 and 111 give the converter sample, 001 gives 0x2000, 010 gives 0x0000 and 011 gives 0x3FFF.
- R7: Pattern 100 alternates 0x2AAA on even-numbered captures and 0x1555 on odd ones. Pattern 101 gives the capture number. Captures are counted from 0 after reset, and the count runs whatever pattern is selected.
- R8: Pattern 110 gives `{cfgUserHi[7:0], cfgUserLo[5:0]}`; `cfgUserLo[7:6]` has no effect.
- R9: The format conversion is applied after pattern selection, so patterns also follow the chosen format.
- R10: `otrOut` shows the captured out-of-range flag when the converter sample is selected (pattern 000 or 111). It is 0 when any other pattern is selected.
- R11: With `cfgDavInvert`=0, `davOut` is 1 exactly on ticks t where (t − `cfgDavPhase`) mod 8 < 4. With `cfgDavInvert`=1 it is the complement of that.
- R12: While `rstN` is low, the tick counter stays at 0, the held word and flag are 0, and the capture count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, eight ticks per sample period |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 14 | Converter sample, offset binary |
| overRange | input | 1 | Out-of-range flag of the sample |
| cfgDdr | input | 1 | Output standard: 0 parallel, 1 double-rate lanes |
| cfgByteOrder | input | 1 | Lane ordering: 0 bit pairs, 1 low/high halves |
| cfgFormat | input | 2 | Number format code |
| cfgPattern | input | 3 | Test pattern select |
| cfgUserHi | input | 8 | User pattern bits 13:6 |
| cfgUserLo | input | 8 | User pattern bits 5:0 in [5:0] |
| cfgDavInvert | input | 1 | Invert the data-valid clock |
| cfgDavPhase | input | 3 | Data-valid delay in ticks |
| parOut | output | 14 | Parallel data bus |
| laneOut | output | 7 | Double-rate data lanes |
| otrOut | output | 1 | Out-of-range output |
| davOut | output | 1 | Data-valid clock |

## Verification
The bench builds the block with its default 14-bit sample and eight-step phase clock. At these sizes every delay setting of the data-valid clock, both lane orderings and every pattern code can be checked, each one tick by tick across whole sample periods. The capture count is short, so the ramp and the alternating pattern can be predicted exactly from the number of periods since reset. A second reset mid-run shows that both restart from zero.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

  typedef enum logic [2:0] {
    PAT_NONE  = 3'b000,
    PAT_MID   = 3'b001,
    PAT_ZERO  = 3'b010,
    PAT_ONES  = 3'b011,
    PAT_ALT   = 3'b100,
    PAT_RAMP  = 3'b101,
    PAT_USER  = 3'b110,
    PAT_SPARE = 3'b111
  } patSel_e;

  typedef enum logic [1:0] {
    FMT_OFFSET = 2'b00,
    FMT_TWOS   = 2'b01,
    FMT_RSV2   = 2'b10,
    FMT_RSV3   = 2'b11
  } fmtSel_e;

  // strobes from the tick sequencer to the datapath
  typedef struct packed {
    logic capture;     // last tick of the sample period
    logic secondHalf;  // ticks of the second lane half
    logic davLevel;    // data-valid clock level after phase and inversion
  } fmtStrobes_t;

endpackage

// File: rtl/adc_fmt_ctrl.sv
module adc_fmt_ctrl
  import adc_fmt_pkg::*;
#(
  parameter int PHASE_STEPS = 8,
  localparam int PH_W = $clog2(PHASE_STEPS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            davInvert,
  input  logic [PH_W-1:0] davPhase,
  output fmtStrobes_t     strobes
);

  localparam int HALF = PHASE_STEPS / 2;

  logic [PH_W-1:0] tickCnt;
  logic [PH_W-1:0] relTick;

  // free-running tick counter; its wrap marks the sample period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickCnt <= '0;
    else       tickCnt <= tickCnt + 1'b1;
  end

  // distance from the programmed data-valid edge, modulo the period
  assign relTick = tickCnt - davPhase;

  always_comb begin
    strobes.capture    = (tickCnt == PH_W'(PHASE_STEPS - 1));
    strobes.secondHalf = (tickCnt >= PH_W'(HALF));
    strobes.davLevel   = (relTick < PH_W'(HALF)) ^ davInvert;
  end

endmodule

// File: rtl/adc_fmt_patgen.sv
module adc_fmt_patgen
  import adc_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                advance,
  input  logic [2:0]          patCode,
  input  logic [SAMPLE_W-1:0] userWord,
  output logic [SAMPLE_W-1:0] patWord,
  output logic                patActive
);

  localparam logic [SAMPLE_W-1:0] MID_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] altOdd;
  logic [SAMPLE_W-1:0] rampCnt;

  // odd bit positions set for the first alternating word
  for (genvar b = 0; b < SAMPLE_W; b++) begin : g_alt
    assign altOdd[b] = (b % 2 == 1);
  end

  // capture count, advanced once per sample period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rampCnt <= '0;
    else if (advance) rampCnt <= rampCnt + 1'b1;
  end

  always_comb begin
    patActive = 1'b1;
    unique case (patSel_e'(patCode))
      PAT_MID:  patWord = MID_CODE;
      PAT_ZERO: patWord = '0;
      PAT_ONES: patWord = '1;
      PAT_ALT:  patWord = rampCnt[0] ? ~altOdd : altOdd;
      PAT_RAMP: patWord = rampCnt;
      PAT_USER: patWord = userWord;
      default: begin
        patWord   = '0;
        patActive = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/adc_fmt_datapath.sv
module adc_fmt_datapath
  import adc_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  localparam int LANES = SAMPLE_W / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  fmtStrobes_t         strobes,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                overRange,
  input  logic [SAMPLE_W-1:0] patWord,
  input  logic                patActive,
  input  logic [1:0]          fmtCode,
  input  logic                ddrMode,
  input  logic                byteOrder,
  output logic [SAMPLE_W-1:0] parOut,
  output logic [LANES-1:0]    laneOut,
  output logic                otrOut,
  output logic                davOut
);

  localparam logic [SAMPLE_W-1:0] SIGN_FLIP = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] selWord;
  logic [SAMPLE_W-1:0] codedWord;
  logic [SAMPLE_W-1:0] heldWord;
  logic                heldOtr;
  logic [LANES-1:0]    firstBits;
  logic [LANES-1:0]    secondBits;

  // pattern first, number format second
  assign selWord   = patActive ? patWord : sampleIn;
  assign codedWord = (fmtSel_e'(fmtCode) == FMT_TWOS) ? (selWord ^ SIGN_FLIP) : selWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
      heldOtr  <= 1'b0;
    end else if (strobes.capture) begin
      heldWord <= codedWord;
      heldOtr  <= overRange & ~patActive;
    end
  end

  // lane folding: neighbouring pairs or low/high halves
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign firstBits[i]  = byteOrder ? heldWord[i]         : heldWord[2*i];
    assign secondBits[i] = byteOrder ? heldWord[LANES + i] : heldWord[2*i + 1];
  end

  assign laneOut = ddrMode ? (strobes.secondHalf ? secondBits : firstBits) : '0;
  assign parOut  = ddrMode ? '0 : heldWord;
  assign otrOut  = heldOtr;
  assign davOut  = strobes.davLevel;

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
  import adc_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int PHASE_STEPS = 8,
  localparam int PH_W = $clog2(PHASE_STEPS),
  localparam int LANES = SAMPLE_W / 2,
  localparam int USER_LO_W = SAMPLE_W - 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                overRange,
  input  logic                cfgDdr,
  input  logic                cfgByteOrder,
  input  logic [1:0]          cfgFormat,
  input  logic [2:0]          cfgPattern,
  input  logic [7:0]          cfgUserHi,
  input  logic [7:0]          cfgUserLo,
  input  logic                cfgDavInvert,
  input  logic [PH_W-1:0]     cfgDavPhase,
  output logic [SAMPLE_W-1:0] parOut,
  output logic [LANES-1:0]    laneOut,
  output logic                otrOut,
  output logic                davOut
);

  fmtStrobes_t         strobes;
  logic [SAMPLE_W-1:0] userWord;
  logic [SAMPLE_W-1:0] patWord;
  logic                patActive;
  logic                unusedUserBits;

  assign userWord       = {cfgUserHi, cfgUserLo[USER_LO_W-1:0]};
  assign unusedUserBits = ^cfgUserLo[7:USER_LO_W];

  adc_fmt_ctrl #(.PHASE_STEPS(PHASE_STEPS)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .davInvert (cfgDavInvert),
    .davPhase  (cfgDavPhase),
    .strobes   (strobes)
  );

  adc_fmt_patgen #(.SAMPLE_W(SAMPLE_W)) patInst (
    .clk       (clk),
    .rstN      (rstN),
    .advance   (strobes.capture),
    .patCode   (cfgPattern),
    .userWord  (userWord),
    .patWord   (patWord),
    .patActive (patActive)
  );

  adc_fmt_datapath #(.SAMPLE_W(SAMPLE_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleIn  (sampleIn),
    .overRange (overRange),
    .patWord   (patWord),
    .patActive (patActive),
    .fmtCode   (cfgFormat),
    .ddrMode   (cfgDdr),
    .byteOrder (cfgByteOrder),
    .parOut    (parOut),
    .laneOut   (laneOut),
    .otrOut    (otrOut),
    .davOut    (davOut)
  );

endmodule

// File: rtl/adc_fmt_checker.sv
module adc_fmt_checker #(
  parameter int SAMPLE_W = 14,
  parameter int PHASE_STEPS = 8,
  localparam int PH_W = $clog2(PHASE_STEPS),
  localparam int LANES = SAMPLE_W / 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgDdr,
  input logic                cfgByteOrder,
  input logic [2:0]          cfgPattern,
  input logic                cfgDavInvert,
  input logic [PH_W-1:0]     cfgDavPhase,
  input logic [SAMPLE_W-1:0] parOut,
  input logic [LANES-1:0]    laneOut,
  input logic                otrOut,
  input logic                davOut
);

  localparam int HALF = PHASE_STEPS / 2;

  logic [PH_W-1:0] myTick;
  logic [PH_W-1:0] myRel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) myTick <= '0;
    else       myTick <= myTick + 1'b1;
  end

  assign myRel = myTick - cfgDavPhase;

  // R11: data-valid level follows the tick count, phase and inversion
  p_dav_window_r11: assert property (@(posedge clk) disable iff (!rstN)
    davOut == ((myRel < PH_W'(HALF)) != cfgDavInvert));

  // R2: lanes idle in parallel mode
  p_lanes_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDdr |-> laneOut == '0);

  // R3: parallel bus idle in lane mode
  p_par_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgDdr |-> parOut == '0);

  // R1: the parallel word changes only at a period boundary
  p_par_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (myTick != '0 && !cfgDdr && !$past(cfgDdr)) |-> $stable(parOut));

  // R4: lanes hold within each half period
  p_lane_half_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDdr && $past(cfgDdr) && $stable(cfgByteOrder) && myTick != '0 &&
     myTick != PH_W'(HALF)) |-> $stable(laneOut));

  // R10: a pattern captured at the boundary clears the range flag
  p_otr_pattern_r10: assert property (@(posedge clk) disable iff (!rstN)
    (myTick == '0 && $past(cfgPattern) != 3'b000 && $past(cfgPattern) != 3'b111)
      |-> !otrOut);

endmodule

bind adc_out_formatter adc_fmt_checker #(
  .SAMPLE_W(SAMPLE_W),
  .PHASE_STEPS(PHASE_STEPS)
) chkInst (
  .clk          (clk),
  .rstN         (rstN),
  .cfgDdr       (cfgDdr),
  .cfgByteOrder (cfgByteOrder),
  .cfgPattern   (cfgPattern),
  .cfgDavInvert (cfgDavInvert),
  .cfgDavPhase  (cfgDavPhase),
  .parOut       (parOut),
  .laneOut      (laneOut),
  .otrOut       (otrOut),
  .davOut       (davOut)
);

// File: tb/adc_out_formatter_test.sv
module adc_out_formatter_test;

  localparam time CLK_PERIOD = 20ns;
  localparam logic [7:0] USER_HI = 8'hA5;
  localparam logic [7:0] USER_LO = 8'hC3;

  typedef struct packed {
    logic        ddr;
    logic        order;
    logic [1:0]  fmt;
    logic [2:0]  pat;
    logic        inv;
    logic [2:0]  phase;
    logic [13:0] sample;
    logic        otr;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 14'h1234, 1'b0},
    '{1'b0, 1'b0, 2'd1, 3'd0, 1'b0, 3'd1, 14'h1234, 1'b1},
    '{1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 3'd2, 14'h3FFF, 1'b1},
    '{1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 3'd3, 14'h2C5A, 1'b0},
    '{1'b1, 1'b1, 2'd0, 3'd0, 1'b1, 3'd4, 14'h2C5A, 1'b0},
    '{1'b1, 1'b1, 2'd1, 3'd0, 1'b1, 3'd5, 14'h0001, 1'b1},
    '{1'b0, 1'b0, 2'd0, 3'd1, 1'b0, 3'd6, 14'h1111, 1'b1},
    '{1'b0, 1'b0, 2'd1, 3'd1, 1'b0, 3'd7, 14'h1111, 1'b0},
    '{1'b0, 1'b0, 2'd0, 3'd2, 1'b1, 3'd0, 14'h3333, 1'b1},
    '{1'b1, 1'b0, 2'd0, 3'd3, 1'b0, 3'd0, 14'h0000, 1'b0},
    '{1'b0, 1'b0, 2'd0, 3'd4, 1'b0, 3'd0, 14'h0F0F, 1'b0},
    '{1'b0, 1'b0, 2'd0, 3'd4, 1'b0, 3'd1, 14'h0F0F, 1'b0},
    '{1'b0, 1'b0, 2'd1, 3'd4, 1'b1, 3'd2, 14'h0F0F, 1'b0},
    '{1'b0, 1'b0, 2'd0, 3'd5, 1'b0, 3'd3, 14'h0000, 1'b1},
    '{1'b1, 1'b0, 2'd0, 3'd5, 1'b0, 3'd4, 14'h0000, 1'b0},
    '{1'b0, 1'b0, 2'd0, 3'd6, 1'b0, 3'd5, 14'h0000, 1'b0},
    '{1'b0, 1'b0, 2'd1, 3'd6, 1'b1, 3'd6, 14'h0000, 1'b1},
    '{1'b0, 1'b0, 2'd0, 3'd7, 1'b0, 3'd7, 14'h0ABC, 1'b1},
    '{1'b0, 1'b0, 2'd2, 3'd0, 1'b0, 3'd0, 14'h3001, 1'b0},
    '{1'b1, 1'b0, 2'd3, 3'd0, 1'b0, 3'd0, 14'h0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] sampleIn = '0;
  logic        overRange = 1'b0;
  logic        cfgDdr = 1'b0;
  logic        cfgByteOrder = 1'b0;
  logic [1:0]  cfgFormat = '0;
  logic [2:0]  cfgPattern = '0;
  logic [7:0]  cfgUserHi = USER_HI;
  logic [7:0]  cfgUserLo = USER_LO;
  logic        cfgDavInvert = 1'b0;
  logic [2:0]  cfgDavPhase = '0;
  logic [13:0] parOut;
  logic [6:0]  laneOut;
  logic        otrOut;
  logic        davOut;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  logic [13:0] prevWord;
  logic        prevOtr;
  string       prevTag;
  int          frameIdx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_out_formatter uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .overRange(overRange),
    .cfgDdr(cfgDdr), .cfgByteOrder(cfgByteOrder), .cfgFormat(cfgFormat),
    .cfgPattern(cfgPattern), .cfgUserHi(cfgUserHi), .cfgUserLo(cfgUserLo),
    .cfgDavInvert(cfgDavInvert), .cfgDavPhase(cfgDavPhase),
    .parOut(parOut), .laneOut(laneOut), .otrOut(otrOut), .davOut(davOut)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  function automatic logic [13:0] modelWord(vec_t v, int k);
    logic [13:0] w;
    case (v.pat)
      3'd1: w = 14'h2000;
      3'd2: w = 14'h0000;
      3'd3: w = 14'h3FFF;
      3'd4: w = (k % 2 == 0) ? 14'h2AAA : 14'h1555;
      3'd5: w = 14'(k);
      3'd6: w = {USER_HI, USER_LO[5:0]};
      default: w = v.sample;
    endcase
    if (v.fmt == 2'b01) w = w ^ 14'h2000;
    return w;
  endfunction

  function automatic string modelTag(vec_t v);
    if (v.pat == 3'd6) return "R8";
    if (v.pat == 3'd4 || v.pat == 3'd5) return "R7";
    if (v.pat != 3'd0 && v.pat != 3'd7 && v.fmt == 2'b01) return "R9";
    if (v.pat != 3'd0 && v.pat != 3'd7) return "R6";
    if (v.fmt == 2'b01) return "R5";
    return "R1";
  endfunction

  function automatic logic [6:0] modelLanes(logic [13:0] w, logic ord, logic half);
    logic [6:0] l;
    for (int i = 0; i < 7; i++)
      l[i] = ord ? w[half ? 7 + i : i] : w[2 * i + (half ? 1 : 0)];
    return l;
  endfunction

  // starts at the negedge of tick 0, returns at the negedge of the next tick 0
  task automatic runFrame(input vec_t v);
    logic [13:0] nextWord;
    logic        nextOtr;
    nextWord = modelWord(v, frameIdx);
    nextOtr  = v.otr && (v.pat == 3'd0 || v.pat == 3'd7);
    sampleIn = v.sample; overRange = v.otr; cfgDdr = v.ddr; cfgByteOrder = v.order;
    cfgFormat = v.fmt; cfgPattern = v.pat; cfgDavInvert = v.inv; cfgDavPhase = v.phase;
    for (int t = 0; t < 8; t++) begin
      #1;
      if (v.ddr) begin
        check("R3", "parOut idle", parOut, 0);
        check(v.order ? "R4" : "R3", {prevTag, " laneOut"}, laneOut,
              modelLanes(prevWord, v.order, t >= 4));
      end else begin
        check(prevTag, "parOut", parOut, prevWord);
        check("R2", "laneOut idle", laneOut, 0);
      end
      check("R10", "otrOut", otrOut, prevOtr);
      check("R11", "davOut", davOut, ((((t - v.phase) & 7) < 4) ? 1 : 0) ^ v.inv);
      @(negedge clk);
    end
    prevWord = nextWord;
    prevOtr  = nextOtr;
    prevTag  = modelTag(v);
    frameIdx++;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    prevWord = '0; prevOtr = 1'b0; prevTag = "R12"; frameIdx = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R12", "parOut in reset", parOut, 0);
    check("R12", "otrOut in reset", otrOut, 0);
    check("R12", "davOut in reset", davOut, 1);
    @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) runFrame(VECS[v]);

    // reset mid-run: held word, range flag and capture count restart
    cfgDavInvert = 1'b1;
    rstN = 1'b0;
    #1;
    check("R12", "parOut in reset", parOut, 0);
    check("R12", "otrOut in reset", otrOut, 0);
    check("R12", "davOut inverted in reset", davOut, 0);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    prevWord = '0; prevOtr = 1'b0; prevTag = "R12"; frameIdx = 0;
    runFrame('{1'b0, 1'b0, 2'd0, 3'd5, 1'b0, 3'd0, 14'h0000, 1'b0});
    runFrame('{1'b0, 1'b0, 2'd0, 3'd4, 1'b0, 3'd0, 14'h0000, 1'b0});
    runFrame('{1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 3'd0, 14'h0000, 1'b0});
    finish();
  end

endmodule